// File: doc/BRIEF.md
# Parallel Port FIFO Interrupt Controller

This block produces the host interrupt for an extended-capability parallel port whose transfer FIFO holds 16 bytes. It follows the FIFO fill level, the transfer direction, whether DMA is selected, an active-low service mask bit, the DMA terminal-count strobe and two peripheral status lines (an active-low fault line and an acknowledge line). Every qualifying event produces a single one-clock pulse on `irq`. The terminal count also sets the service mask bit again, which stops DMA.

The host writes the control fields through `ctl_wr` and the two threshold fields through `thr_wr`. The FIFO reports its occupancy on `fifo_level`. A small state machine holds the service bit and the transfer mode. It has three states:
- MASKED: the service bit is 1.
- PIO_RUN: the service bit is 0 and DMA is off.
- DMA_RUN: the service bit is 0 and DMA is on.

A control write moves the machine as follows:
- to MASKED when the service field is 1;
- otherwise to DMA_RUN when the DMA field is 1;
- otherwise to PIO_RUN.

A terminal count in DMA_RUN moves the machine to MASKED, and it takes priority over a control write in the same cycle. The threshold condition is evaluated only in PIO_RUN, so entering PIO_RUN while the FIFO already qualifies raises an interrupt. The fault and acknowledge lines are asynchronous and pass through two-flop synchronizers.

Top module: `ppfifo_irq_ctrl`

## Requirements
- R1: After reset the service bit is 1 (`svc_bit`=1). A control write with `ctl_svc`=0 that enters PIO_RUN while the threshold condition already holds pulses `irq` two cycles after the write is sampled. Writing `ctl_svc`=1 stops threshold interrupts, and clearing it again re-arms them.
- R2: A control write with `ctl_dma_en`=1 and `ctl_svc`=0 enters DMA_RUN (`dma_run`=1). In DMA_RUN a `dma_tc` strobe pulses `irq` in the cycle after it is sampled, and also sets `svc_bit`=1 and `dma_run`=0. A strobe outside DMA_RUN has no effect.
- R3: In PIO_RUN with `ctl_dir`=0 (write direction), the condition is free bytes (16 − `fifo_level`) ≥ write threshold. When the condition becomes true, `irq` pulses in the next cycle. One byte short of the threshold raises nothing.
- R4: In PIO_RUN with `ctl_dir`=1 (read direction), the condition is `fifo_level` ≥ read threshold. When the condition becomes true, `irq` pulses in the next cycle.
- R5: Each effective threshold is its 4-bit field plus one, giving a range of 1 to 16. Field 0 triggers at one byte and field 15 triggers only at 16 bytes.
- R6: While `ctl_err_mask_n`=0, a falling edge on `fault_n` raises an interrupt. A control write that changes `ctl_err_mask_n` from 1 to 0 while `fault_n` is low raises one two cycles after the write. With the enable at 1, fault edges raise nothing.
- R7: While `ctl_ack_en`=1, a rising edge on `ack_in` raises an interrupt. Falling edges, and any edge while the enable is 0, raise nothing.
- R8: Both status lines are synchronized by two flops. A pin edge placed before clock edge n shows on `irq` after clock edge n+2.
- R9: Reset leaves `irq`=0, `svc_bit`=1 and `dma_run`=0, with the error enable at 1 and the acknowledge enable at 0. A FIFO level that would qualify raises nothing until the service bit is cleared.
- R10: `irq` is a one-clock pulse per event. A threshold condition that stays true never raises a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control field write strobe |
| ctl_dma_en | input | 1 | DMA select written with ctl_wr |
| ctl_dir | input | 1 | Direction, 0 = host to port, 1 = port to host |
| ctl_svc | input | 1 | Service mask bit, 0 enables interrupts |
| ctl_err_mask_n | input | 1 | Active-low fault interrupt enable |
| ctl_ack_en | input | 1 | Acknowledge interrupt enable |
| thr_wr | input | 1 | Threshold fields write strobe |
| thr_wr_field | input | 4 | Write-direction threshold minus one |
| thr_rd_field | input | 4 | Read-direction threshold minus one |
| fifo_level | input | 5 | Bytes currently held in the FIFO, 0 to 16 |
| dma_tc | input | 1 | DMA terminal-count strobe |
| fault_n | input | 1 | Asynchronous active-low fault line |
| ack_in | input | 1 | Asynchronous acknowledge line |
| irq | output | 1 | One-clock interrupt pulse |
| svc_bit | output | 1 | Current service mask bit |
| dma_run | output | 1 | DMA transfers enabled |

## Verification
The threshold logic is driven in both directions at levels one byte short of the threshold and exactly at it. This separates a correct ≥ compare from an off-by-one and from a swapped free/held count. The thresholds are also driven at field values 0 and 15, which exposes a missing +1. Re-arming by clearing the service bit is contrasted with a condition held steady and with a direction change. Together these separate the level-qualified rearm from plain edge detection. The fault and acknowledge lines are toggled with their enables on and off, in both polarities, and the expected pulse cycle pins down the synchronizer depth.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;

    typedef enum logic [1:0] {
        ST_MASKED   = 2'd0,
        ST_PIO_RUN  = 2'd1,
        ST_DMA_RUN  = 2'd2
    } svc_state_t;

    typedef struct packed {
        logic dir;
        logic err_mask_n;
        logic ack_en;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{dir: 1'b0, err_mask_n: 1'b1, ack_en: 1'b0};

endpackage

// File: rtl/ppirq_cfg.sv
module ppirq_cfg
    import ppirq_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_dir,
    input  logic             ctl_err_mask_n,
    input  logic             ctl_ack_en,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wr_field,
    input  logic [THR_W-1:0] thr_rd_field,
    output ctl_fields_t      ctl_q,
    output logic [THR_W-1:0] wr_thr_q,
    output logic [THR_W-1:0] rd_thr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl_q <= '{dir: ctl_dir, err_mask_n: ctl_err_mask_n, ack_en: ctl_ack_en};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_thr_q <= '0;
            rd_thr_q <= '0;
        end else if (thr_wr) begin
            wr_thr_q <= thr_wr_field;
            rd_thr_q <= thr_rd_field;
        end
    end

endmodule

// File: rtl/ppirq_edge.sv
module ppirq_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    input  logic ack_in,
    input  logic err_mask_n,
    input  logic ack_en,
    output logic fault_evt,
    output logic ack_evt
);

    localparam logic [1:0] LINE_IDLE = 2'b01;

    logic [1:0] pin_vec;
    logic [1:0] stage_q [SYNC_STAGES];
    logic [1:0] synced;
    logic [1:0] synced_d;
    logic       err_mask_prev;

    assign pin_vec = {ack_in, fault_n};

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[gi] <= LINE_IDLE;
                end else if (gi == 0) begin
                    stage_q[gi] <= pin_vec;
                end else begin
                    stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_d      <= LINE_IDLE;
            err_mask_prev <= 1'b1;
        end else begin
            synced_d      <= synced;
            err_mask_prev <= err_mask_n;
        end
    end

    logic fault_fall;
    logic fault_unmask_low;
    logic ack_rise;

    assign fault_fall       = synced_d[0] & ~synced[0];
    assign fault_unmask_low = err_mask_prev & ~err_mask_n & ~synced[0];
    assign ack_rise         = ~synced_d[1] & synced[1];

    assign fault_evt = (~err_mask_n & fault_fall) | fault_unmask_low;
    assign ack_evt   = ack_en & ack_rise;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> !ack_evt); // R7

endmodule

// File: rtl/ppirq_thr.sv
module ppirq_thr #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pio_run,
    input  logic             dir,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] wr_thr,
    input  logic [THR_W-1:0] rd_thr,
    output logic             cond,
    output logic             rise
);

    logic [LVL_W-1:0] wr_eff;
    logic [LVL_W-1:0] rd_eff;
    logic [LVL_W-1:0] free_bytes;
    logic             wr_ok;
    logic             rd_ok;
    logic             cond_q;

    assign wr_eff     = LVL_W'(wr_thr) + LVL_W'(1);
    assign rd_eff     = LVL_W'(rd_thr) + LVL_W'(1);
    assign free_bytes = LVL_W'(DEPTH) - level;

    assign wr_ok = (free_bytes >= wr_eff);
    assign rd_ok = (level >= rd_eff);

    assign cond = pio_run & (dir ? rd_ok : wr_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond;
        end
    end

    assign rise = cond & ~cond_q;

    AST_THR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R10

endmodule

// File: rtl/ppirq_fsm.sv
module ppirq_fsm
    import ppirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_dma_en,
    input  logic ctl_svc,
    input  logic dma_tc,
    input  logic thr_rise,
    input  logic fault_evt,
    input  logic ack_evt,
    output logic svc_bit,
    output logic dma_run,
    output logic pio_run,
    output logic irq
);

    svc_state_t state_q;
    svc_state_t state_d;
    logic       tc_evt;

    assign tc_evt = (state_q == ST_DMA_RUN) & dma_tc;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED: begin
                if (ctl_wr && !ctl_svc) begin
                    state_d = ctl_dma_en ? ST_DMA_RUN : ST_PIO_RUN;
                end
            end
            ST_PIO_RUN: begin
                if (ctl_wr) begin
                    if (ctl_svc)         state_d = ST_MASKED;
                    else if (ctl_dma_en) state_d = ST_DMA_RUN;
                end
            end
            ST_DMA_RUN: begin
                if (dma_tc) begin
                    state_d = ST_MASKED;
                end else if (ctl_wr) begin
                    if (ctl_svc)          state_d = ST_MASKED;
                    else if (!ctl_dma_en) state_d = ST_PIO_RUN;
                end
            end
            default: state_d = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MASKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= tc_evt | thr_rise | fault_evt | ack_evt;
        end
    end

    assign svc_bit = (state_q == ST_MASKED);
    assign dma_run = (state_q == ST_DMA_RUN);
    assign pio_run = (state_q == ST_PIO_RUN);

    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_run && dma_tc) |=> (svc_bit && irq)); // R2
    AST_THR_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        thr_rise |=> irq); // R3
    AST_FAULT_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> irq); // R6
    AST_ACK_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> irq); // R7
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_bit && !ctl_wr) |=> svc_bit); // R1

endmodule

// File: rtl/ppfifo_irq_ctrl.sv
module ppfifo_irq_ctrl
    import ppirq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_dma_en,
    input  logic             ctl_dir,
    input  logic             ctl_svc,
    input  logic             ctl_err_mask_n,
    input  logic             ctl_ack_en,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wr_field,
    input  logic [THR_W-1:0] thr_rd_field,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dma_tc,
    input  logic             fault_n,
    input  logic             ack_in,
    output logic             irq,
    output logic             svc_bit,
    output logic             dma_run
);

    ctl_fields_t      ctl_q;
    logic [THR_W-1:0] wr_thr_q;
    logic [THR_W-1:0] rd_thr_q;
    logic             pio_run;
    logic             thr_cond;
    logic             thr_rise;
    logic             fault_evt;
    logic             ack_evt;

    ppirq_cfg #(.THR_W(THR_W)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_wr         (ctl_wr),
        .ctl_dir        (ctl_dir),
        .ctl_err_mask_n (ctl_err_mask_n),
        .ctl_ack_en     (ctl_ack_en),
        .thr_wr         (thr_wr),
        .thr_wr_field   (thr_wr_field),
        .thr_rd_field   (thr_rd_field),
        .ctl_q          (ctl_q),
        .wr_thr_q       (wr_thr_q),
        .rd_thr_q       (rd_thr_q)
    );

    ppirq_edge #(.SYNC_STAGES(2)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_n    (fault_n),
        .ack_in     (ack_in),
        .err_mask_n (ctl_q.err_mask_n),
        .ack_en     (ctl_q.ack_en),
        .fault_evt  (fault_evt),
        .ack_evt    (ack_evt)
    );

    ppirq_thr #(.DEPTH(DEPTH)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pio_run (pio_run),
        .dir     (ctl_q.dir),
        .level   (fifo_level),
        .wr_thr  (wr_thr_q),
        .rd_thr  (rd_thr_q),
        .cond    (thr_cond),
        .rise    (thr_rise)
    );

    ppirq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_dma_en (ctl_dma_en),
        .ctl_svc    (ctl_svc),
        .dma_tc     (dma_tc),
        .thr_rise   (thr_rise),
        .fault_evt  (fault_evt),
        .ack_evt    (ack_evt),
        .svc_bit    (svc_bit),
        .dma_run    (dma_run),
        .pio_run    (pio_run),
        .irq        (irq)
    );

    AST_MASKED_NO_COND: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bit |-> !thr_cond); // R1

endmodule

// File: tb/tb_ppfifo_irq_ctrl.sv
module tb_ppfifo_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_dma_en = 1'b0, ctl_dir = 1'b0, ctl_svc = 1'b1;
    logic       ctl_err_mask_n = 1'b1, ctl_ack_en = 1'b0;
    logic       thr_wr = 1'b0;
    logic [3:0] thr_wr_field = '0, thr_rd_field = '0;
    logic [4:0] fifo_level = '0;
    logic       dma_tc = 1'b0, fault_n = 1'b1, ack_in = 1'b0;
    logic       irq, svc_bit, dma_run;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int    exp_cyc[$];
    string exp_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ppfifo_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_dma_en(ctl_dma_en),
        .ctl_dir(ctl_dir), .ctl_svc(ctl_svc), .ctl_err_mask_n(ctl_err_mask_n),
        .ctl_ack_en(ctl_ack_en), .thr_wr(thr_wr), .thr_wr_field(thr_wr_field),
        .thr_rd_field(thr_rd_field), .fifo_level(fifo_level), .dma_tc(dma_tc),
        .fault_n(fault_n), .ack_in(ack_in), .irq(irq), .svc_bit(svc_bit),
        .dma_run(dma_run)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(int c, string tag);
        exp_cyc.push_back(c);
        exp_tag.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                check(0, {exp_tag[0], " missed irq"}, -1, exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_tag.pop_front());
            end
            if (irq) begin
                if (exp_cyc.size() == 0) begin
                    check(0, "R10 unexpected irq", cyc, -1);
                end else begin
                    check(exp_cyc[0] == cyc, exp_tag[0], cyc, exp_cyc[0]);
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_ctl(bit dma, bit dir, bit svc, bit errn, bit acken, bit exp, string tag);
        @(negedge clk);
        ctl_wr = 1; ctl_dma_en = dma; ctl_dir = dir; ctl_svc = svc;
        ctl_err_mask_n = errn; ctl_ack_en = acken;
        if (exp) push_exp(cyc + 2, tag);
        @(negedge clk);
        ctl_wr = 0;
        idle(5);
    endtask

    task automatic wr_thr(int w, int r);
        @(negedge clk);
        thr_wr = 1; thr_wr_field = 4'(w); thr_rd_field = 4'(r);
        @(negedge clk);
        thr_wr = 0;
        idle(5);
    endtask

    task automatic set_level(int v, bit exp, string tag);
        @(negedge clk);
        fifo_level = 5'(v);
        if (exp) push_exp(cyc + 1, tag);
        idle(6);
    endtask

    task automatic tc_pulse(bit exp, string tag);
        @(negedge clk);
        dma_tc = 1;
        if (exp) push_exp(cyc + 1, tag);
        @(negedge clk);
        dma_tc = 0;
        idle(5);
    endtask

    task automatic set_fault(bit v, bit exp, string tag);
        @(negedge clk);
        fault_n = v;
        if (exp) push_exp(cyc + 3, tag);
        idle(7);
    endtask

    task automatic set_ack(bit v, bit exp, string tag);
        @(negedge clk);
        ack_in = v;
        if (exp) push_exp(cyc + 3, tag);
        idle(7);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1;
        // R9: reset state, level 0 would satisfy write threshold yet nothing fires
        check(irq == 0, "R9 irq after reset", irq, 0);
        check(svc_bit == 1, "R9 svc_bit after reset", svc_bit, 1);
        check(dma_run == 0, "R9 dma_run after reset", dma_run, 0);
        idle(8);

        // R3 / R1: write direction, threshold 4
        wr_thr(3, 7);
        wr_ctl(0, 0, 0, 1, 0, 1, "R1 clear svc with condition true");
        check(svc_bit == 0, "R1 svc_bit cleared", svc_bit, 0);
        idle(10); // R10: no repeat while condition holds
        set_level(13, 0, "");
        set_level(12, 1, "R3 free bytes equal threshold");
        set_level(11, 0, "R10 condition stays true");
        // R1 re-arm
        wr_ctl(0, 0, 1, 1, 0, 0, "");
        check(svc_bit == 1, "R1 svc_bit set", svc_bit, 1);
        wr_ctl(0, 0, 0, 1, 0, 1, "R1 re-arm by clearing svc");

        // R4: read direction, threshold 8
        wr_ctl(0, 0, 1, 1, 0, 0, "");
        set_level(7, 0, "");
        wr_ctl(0, 1, 0, 1, 0, 0, "");
        set_level(8, 1, "R4 held bytes equal threshold");
        set_level(16, 0, "R10 still true");

        // R5: field 15 -> 16, field 0 -> 1
        wr_thr(3, 15);
        set_level(15, 0, "");
        set_level(16, 1, "R5 threshold field 15");
        wr_thr(3, 0);
        set_level(0, 0, "");
        set_level(1, 1, "R5 threshold field 0");

        // R2: DMA terminal count
        wr_ctl(0, 1, 1, 1, 0, 0, "");
        wr_ctl(1, 1, 0, 1, 0, 0, "");
        check(dma_run == 1, "R2 dma_run on", dma_run, 1);
        tc_pulse(1, "R2 terminal count irq");
        check(svc_bit == 1, "R2 svc set by tc", svc_bit, 1);
        check(dma_run == 0, "R2 dma stopped by tc", dma_run, 0);
        tc_pulse(0, "");
        check(svc_bit == 1, "R2 tc while masked keeps svc", svc_bit, 1);
        wr_ctl(0, 1, 0, 1, 0, 1, "R1 enter PIO with level 1");
        tc_pulse(0, "");
        check(svc_bit == 0, "R2 tc in PIO ignored", svc_bit, 0);
        wr_ctl(0, 1, 1, 1, 0, 0, "");

        // R6 / R8: fault
        wr_ctl(0, 1, 1, 0, 0, 0, "");
        set_fault(0, 1, "R8 R6 fault fall three cycles");
        set_fault(1, 0, "");
        wr_ctl(0, 1, 1, 1, 0, 0, "");
        set_fault(0, 0, "");
        wr_ctl(0, 1, 1, 0, 0, 1, "R6 enable cleared while fault low");
        wr_ctl(0, 1, 1, 0, 0, 0, "");
        set_fault(1, 0, "");

        // R7 / R8: acknowledge
        set_ack(1, 0, "");
        set_ack(0, 0, "");
        wr_ctl(0, 1, 1, 0, 1, 0, "");
        set_ack(1, 1, "R8 R7 ack rise three cycles");
        set_ack(0, 0, "");
        check(svc_bit == 1, "R7 ack leaves svc", svc_bit, 1);

        idle(10);
        finished = 1;
        while (exp_cyc.size() > 0) begin
            check(0, {exp_tag[0], " never seen"}, -1, exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_tag.pop_front());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule